// File: doc/BRIEF.md
# Two-Wire Memory Write Target with Busy Polling

This block is the write side of a two-wire serial target that fronts a small byte-addressed nonvolatile array. It watches the clock and data lines, recognises start and stop conditions, checks the 7-bit device address, takes one word-address byte, and then accepts data bytes. It acknowledges each byte by driving a pull-down enable for the data line. Each accepted data byte is handed to an external page buffer through a single-cycle strobe that carries the byte and its target address. The address walks forward inside one page and wraps back to the start of that page.

When a stop condition closes a write that delivered at least one data byte, the block pulses a commit strobe and starts an internal write timer. While the timer runs, the block leaves the data line released and acknowledges nothing, not even its own device address. A host can therefore poll until it gets an acknowledge. A write-protect input is sampled once per transaction, on the clock falling edge that ends the word-address acknowledge slot. If it is high at that point, the first data byte is refused and the whole write is dropped.

The bus lines and the protect input pass through a two-stage synchronizer. They are sampled by a system clock that runs at least eight times faster than the bus clock.

Top module: `eeprom_wr_target`

## Requirements
- R1: After reset the data-line pull-down is released, the busy flag is low and neither the byte strobe nor the commit strobe is asserted.
- R2: When not busy, a device-address byte whose upper seven bits equal DEV_ADDR and whose least significant (read/write) bit is 0 is acknowledged. The pull-down is active while SCL is high in the ninth bit. The word-address byte and the data bytes that follow are acknowledged in the same way.
- R3: Each acknowledged data byte produces exactly one single-cycle `wr_stb_o` pulse with the byte on `wr_data_o` and its target address on `wr_addr_o`.
- R4: The first data byte goes to the word address given by the host. Each further byte goes to the next address, where only the low PAGE_W bits count up (modulo 2^PAGE_W) and the upper bits stay fixed. With PAGE_W = 4, a write from 0x3E goes to 0x3E, 0x3F, 0x30, 0x31.
- R5: A stop condition that ends a write with at least one accepted data byte produces one `commit_o` pulse. `busy_o` rises on the next cycle and stays high for exactly TWR_CYCLES system clock cycles.
- R6: While `busy_o` is high, no byte is acknowledged, including a matching device address with read/write bit 0. The pull-down stays released and no byte strobe is issued.
- R7: Once `busy_o` has fallen, the next matching device address is acknowledged normally.
- R8: A device-address byte with the wrong upper seven bits, or with the read/write bit equal to 1, is not acknowledged. Every byte after it is ignored (no acknowledge, no strobe) until the next start condition.
- R9: Write protect is sampled on the SCL falling edge that ends the word-address acknowledge slot. If it is high there, the first data byte is not acknowledged, no byte strobe is issued, and the following stop starts no write cycle.
- R10: The protect level at any other time has no effect. A write whose protect input is high only before or after the sample edge completes normally.
- R11: A stop condition that arrives after the word address but before any data byte produces no commit pulse and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wp_i | input | 1 | Write protect, high blocks writes |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 drives low) |
| wr_stb_o | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr_o | output | 8 | Target address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle pulse starting the internal write |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A wrong protocol state shows within one byte time at the ports. An acknowledge is missing or appears where none belongs, or a strobe carries the wrong address or none at all. A mistimed or misloaded write timer shows as a busy window of the wrong length, or as an acknowledge given to a polling host before the window ends. A protect sample taken at the wrong edge shows as an accepted or refused first data byte that differs from the level present at the word-address acknowledge fall.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

  localparam int unsigned WADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DEV      = 3'd1,
    ST_DEV_ACK  = 3'd2,
    ST_WADR     = 3'd3,
    ST_WADR_ACK = 3'd4,
    ST_DATA     = 3'd5,
    ST_DATA_ACK = 3'd6
  } wr_state_e;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_bit,
  output logic wp_s,
  output logic start_det,
  output logic stop_det
);

  // bit 0 = scl, bit 1 = sda, bit 2 = write protect
  localparam logic [2:0] IDLE_LVL = 3'b011;

  logic [2:0] stg_q [SYNC_STAGES];
  logic       scl_p_q, sda_p_q;
  logic       scl_s, sda_s;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= IDLE_LVL;
        else        stg_q[g] <= {wp_i, sda_i, scl_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= IDLE_LVL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign scl_s = stg_q[SYNC_STAGES-1][0];
  assign sda_s = stg_q[SYNC_STAGES-1][1];
  assign wp_s  = stg_q[SYNC_STAGES-1][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  assign sda_bit   = sda_s;
  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
  parameter int unsigned TWR_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);

  localparam int unsigned CNT_W = $clog2(TWR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = CNT_W'(TWR_CYCLES);
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/i2c_wr_proto.sv
module i2c_wr_proto
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h50,
  parameter int unsigned PAGE_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_bit,
  input  logic               wp_s,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               busy_i,
  output logic               sda_oe_o,
  output logic               wr_stb_o,
  output logic [WADDR_W-1:0] wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               commit_o
);

  localparam int unsigned BASE_W = WADDR_W - PAGE_W;

  wr_state_e          st_q, st_d;
  logic [2:0]         bit_q, bit_d;
  logic [6:0]         sh_q, sh_d;
  logic               oe_q, oe_d;
  logic [BASE_W-1:0]  base_q, base_d;
  logic [PAGE_W-1:0]  off_q, off_d;
  logic               wp_q, wp_d;
  logic               any_q, any_d;
  logic               stb_q, stb_d;
  logic [WADDR_W-1:0] addr_q, addr_d;
  logic [7:0]         data_q, data_d;
  logic               commit_q, commit_d;

  logic [7:0] byte_w;
  logic       last_bit;
  logic       rx_ack;

  assign byte_w   = {sh_q, sda_bit};
  assign last_bit = (bit_q == 3'd7);

  // acknowledge decision for the byte that completes on this rising edge
  always_comb begin
    unique case (st_q)
      ST_DEV:  rx_ack = (byte_w[7:1] == DEV_ADDR) && !byte_w[0] && !busy_i;
      ST_WADR: rx_ack = 1'b1;
      ST_DATA: rx_ack = any_q || !wp_q;
      default: rx_ack = 1'b0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    base_d   = base_q;
    off_d    = off_q;
    wp_d     = wp_q;
    any_d    = any_q;
    stb_d    = 1'b0;
    addr_d   = addr_q;
    data_d   = data_q;
    commit_d = 1'b0;

    if (stop_det) begin
      st_d     = ST_IDLE;
      oe_d     = 1'b0;
      commit_d = any_q;
      any_d    = 1'b0;
    end else if (start_det) begin
      st_d  = ST_DEV;
      bit_d = 3'd0;
      oe_d  = 1'b0;
      any_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADR, ST_DATA: begin
          if (scl_rise) begin
            sh_d  = byte_w[6:0];
            bit_d = bit_q + 3'd1;
            if (last_bit) begin
              if (!rx_ack) begin
                st_d = ST_IDLE;
              end else if (st_q == ST_DEV) begin
                st_d = ST_DEV_ACK;
              end else if (st_q == ST_WADR) begin
                st_d   = ST_WADR_ACK;
                base_d = byte_w[WADDR_W-1:PAGE_W];
                off_d  = byte_w[PAGE_W-1:0];
              end else begin
                st_d   = ST_DATA_ACK;
                stb_d  = 1'b1;
                addr_d = {base_q, off_q};
                data_d = byte_w;
                off_d  = off_q + PAGE_W'(1);
                any_d  = 1'b1;
              end
            end
          end
        end
        ST_DEV_ACK, ST_WADR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            if (!oe_q) begin
              oe_d = 1'b1;
            end else begin
              oe_d  = 1'b0;
              bit_d = 3'd0;
              if (st_q == ST_DEV_ACK) begin
                st_d = ST_WADR;
              end else begin
                st_d = ST_DATA;
                if (st_q == ST_WADR_ACK) wp_d = wp_s;
              end
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      base_q   <= '0;
      off_q    <= '0;
      wp_q     <= 1'b0;
      any_q    <= 1'b0;
      stb_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      oe_q     <= oe_d;
      base_q   <= base_d;
      off_q    <= off_d;
      wp_q     <= wp_d;
      any_q    <= any_d;
      stb_q    <= stb_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      commit_q <= commit_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_stb_o  = stb_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
  assign commit_o  = commit_q;

endmodule

// File: rtl/eeprom_wr_target.sv
module eeprom_wr_target
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned TWR_CYCLES  = 1250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       commit_o,
  output logic       busy_o
);

  logic scl_rise, scl_fall, sda_bit, wp_s, start_det, stop_det;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .wp_i      (wp_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_bit   (sda_bit),
    .wp_s      (wp_s),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_wr_proto #(.DEV_ADDR(DEV_ADDR), .PAGE_W(PAGE_W)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_bit   (sda_bit),
    .wp_s      (wp_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy_i    (busy_o),
    .sda_oe_o  (sda_oe_o),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .commit_o  (commit_o)
  );

  i2c_wr_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (commit_o),
    .busy_o (busy_o)
  );

endmodule

// File: rtl/eeprom_wr_chk.sv
module eeprom_wr_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wr_stb_o,
  input logic commit_o,
  input logic busy_o
);

  // R6: nothing is acknowledged or strobed during the internal write
  a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!sda_oe_o && !wr_stb_o));

  // R5: commit launches the busy window
  a_r5_commit_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> busy_o);

  // R5: a commit never lands inside a running write cycle
  a_r5_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !busy_o);

  // R3: one byte gives a single-cycle strobe
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R2: the pull-down only starts while the bus clock is low
  a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

endmodule

bind eeprom_wr_target eeprom_wr_chk u_chk (.*);

// File: tb/eeprom_wr_target_tb.sv
`timescale 1ns/1ps
module eeprom_wr_target_tb;

  localparam logic [6:0] DEV  = 7'h50;
  localparam int         TWR  = 600;
  localparam int         HALF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic host_scl, host_sda, wp;
  logic sda_oe, wr_stb, commit, busy;
  logic [7:0] wr_addr, wr_data;
  logic sda_line;

  always #2 clk = ~clk;

  assign sda_line = host_sda & ~sda_oe;

  eeprom_wr_target #(.DEV_ADDR(DEV), .PAGE_W(4), .TWR_CYCLES(TWR)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (host_scl),
    .sda_i     (sda_line),
    .wp_i      (wp),
    .sda_oe_o  (sda_oe),
    .wr_stb_o  (wr_stb),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .commit_o  (commit),
    .busy_o    (busy)
  );

  int checks = 0;
  int errors = 0;

  // port monitor
  logic [7:0] stb_addr [256];
  logic [7:0] stb_data [256];
  int stb_n = 0;
  int commit_n = 0;
  int busy_len = 0;
  logic [7:0] tx_data [32];

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_stb && stb_n < 256) begin
        stb_addr[stb_n] <= wr_addr;
        stb_data[stb_n] <= wr_data;
        stb_n <= stb_n + 1;
      end
      if (commit) begin
        commit_n <= commit_n + 1;
        busy_len <= 0;
      end else if (busy) begin
        busy_len <= busy_len + 1;
      end
    end
  end

  function automatic logic [7:0] exp_addr(input logic [7:0] a, input int i);
    exp_addr = {a[7:4], 4'(int'(a[3:0]) + i)};
  endfunction

  function automatic int exp_dev_ack(input logic [7:0] b, input logic bsy);
    exp_dev_ack = ((b[7:1] == DEV) && !b[0] && !bsy) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1;
    tick(HALF);
    host_scl = 1'b1;
    tick(2 * HALF);
    host_sda = 1'b0;
    tick(2 * HALF);
    host_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(HALF);
    host_sda = 1'b0;
    tick(HALF);
    host_scl = 1'b1;
    tick(2 * HALF);
    host_sda = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    tick(HALF);
    host_sda = b;
    tick(HALF);
    host_scl = 1'b1;
    tick(HALF);
    seen = sda_line;
    tick(HALF);
    host_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    logic seen;
    for (int i = 7; i >= 0; i--) send_bit(b[i], seen);
    send_bit(1'b1, seen);
    ack = seen ? 0 : 1;
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(4);
  endtask

  // full write with every byte expected to be acknowledged
  task automatic run_write(input logic [7:0] waddr, input int len, input string tag);
    int s0, c0, ack;
    s0 = stb_n;
    c0 = commit_n;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk({tag, " R2 device ack"}, ack, 1);
    send_byte(waddr, ack);
    chk({tag, " R2 word address ack"}, ack, 1);
    for (int i = 0; i < len; i++) begin
      tx_data[i] = 8'($urandom);
      send_byte(tx_data[i], ack);
      chk({tag, " R2 data ack"}, ack, 1);
    end
    bus_stop();
    tick(2);
    chk({tag, " R3 strobe count"}, stb_n - s0, len);
    for (int i = 0; i < len; i++) begin
      chk({tag, " R4 strobe address"}, int'(stb_addr[s0 + i]), int'(exp_addr(waddr, i)));
      chk({tag, " R3 strobe data"}, int'(stb_data[s0 + i]), int'(tx_data[i]));
    end
    chk({tag, " R5 one commit"}, commit_n - c0, 1);
    chk({tag, " R5 busy after stop"}, int'(busy), 1);
    wait_idle();
    chk({tag, " R5 busy length"}, busy_len, TWR);
  endtask

  initial begin
    int ack, s0, c0;
    void'($urandom(32'd4242));
    host_scl = 1'b1;
    host_sda = 1'b1;
    wp = 1'b0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // reset state
    chk("R1 pull-down released", int'(sda_oe), 0);
    chk("R1 busy low", int'(busy), 0);
    chk("R1 no strobe", stb_n, 0);
    chk("R1 no commit", commit_n, 0);

    // single byte write
    run_write(8'h25, 1, "byte");

    // page write across the page end
    run_write(8'h3E, 4, "wrap");

    // polling during the internal write
    s0 = stb_n;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h10, ack);
    send_byte(8'h77, ack);
    bus_stop();
    chk("R5 poll setup busy", int'(busy), 1);
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk("R6 no ack while busy", ack, exp_dev_ack({DEV, 1'b0}, 1'b1));
    bus_stop();
    chk("R6 busy still high", int'(busy), 1);
    chk("R6 no strobe while busy", stb_n - s0, 1);
    wait_idle();
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk("R7 ack after busy ends", ack, 1);
    bus_stop();
    chk("R11 no commit without data", int'(busy), 0);

    // wrong device address, then further bytes ignored
    s0 = stb_n;
    c0 = commit_n;
    bus_start();
    send_byte({7'h51, 1'b0}, ack);
    chk("R8 wrong address nack", ack, exp_dev_ack({7'h51, 1'b0}, 1'b0));
    send_byte(8'h00, ack);
    chk("R8 later byte ignored", ack, 0);
    send_byte(8'h5A, ack);
    chk("R8 data ignored", ack, 0);
    bus_stop();
    chk("R8 no strobe", stb_n - s0, 0);
    chk("R8 no commit", commit_n - c0, 0);

    // read request is refused
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk("R8 read bit nack", ack, 0);
    bus_stop();

    // stop right after word address
    c0 = commit_n;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h44, ack);
    chk("R11 word address ack", ack, 1);
    bus_stop();
    tick(4);
    chk("R11 no commit", commit_n - c0, 0);
    chk("R11 busy stays low", int'(busy), 0);

    // protect high at the sample edge
    s0 = stb_n;
    c0 = commit_n;
    wp = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk("R9 device ack under protect", ack, 1);
    send_byte(8'h60, ack);
    chk("R9 word address ack under protect", ack, 1);
    send_byte(8'hC3, ack);
    chk("R9 first data nack", ack, 0);
    bus_stop();
    wp = 1'b0;
    tick(4);
    chk("R9 no strobe", stb_n - s0, 0);
    chk("R9 no commit", commit_n - c0, 0);
    chk("R9 no busy", int'(busy), 0);

    // protect high only away from the sample edge
    s0 = stb_n;
    c0 = commit_n;
    wp = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    wp = 1'b0;
    send_byte(8'h81, ack);
    tick(2);
    wp = 1'b1;
    send_byte(8'h9B, ack);
    chk("R10 first data ack", ack, 1);
    send_byte(8'h2C, ack);
    chk("R10 second data ack", ack, 1);
    bus_stop();
    wp = 1'b0;
    tick(2);
    chk("R10 strobes", stb_n - s0, 2);
    chk("R10 strobe address", int'(stb_addr[s0 + 1]), 8'h82);
    chk("R10 commit", commit_n - c0, 1);
    wait_idle();

    // random page writes, some long enough to wrap twice
    for (int k = 0; k < 6; k++) begin
      run_write(8'($urandom), 1 + int'($urandom % 20), "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule